// File: doc/BRIEF.md
# Execution Set Placement Checker and Unit Router

This block accepts one decoded execution set per cycle. A set is a row of up to eight word slots. Each slot carries:

- a valid bit;
- a 3-bit class (NOP, DALU, AGU, prefix or extension word);
- a two-word flag;
- a 2-bit conditional subgroup tag;
- a flag that marks an instruction able to update the carry bit.

The block checks the set against the placement rules that let the issue stage wire each slot position to a fixed execution unit. A DALU instruction goes to the ALU picked by its position modulo four. An AGU instruction goes to the AGU picked by the parity of its position.

For a legal set, the block raises one valid and one slot index per unit. It also names the single instruction allowed to write the carry bit. For an illegal set, it reports the highest-priority violation and dispatches nothing.

The result is registered and handed on with a valid/ready handshake. When downstream stalls, the result stays in the register and the input is refused. Decoding, execution and the reordering of instructions are outside this block.

Top module: `xset_dispatch`

## Requirements
- R1: If any occupied slot has an empty slot below it, the set is illegal with code 7'b0000001 (gap).
- R2: More than two AGU instructions (class 3'd2) give code 7'b0000010.
- R3: Two AGU instructions whose positions have equal parity give code 7'b0000100. A single AGU instruction is legal at any position.
- R4: More than four DALU instructions (class 3'd1) give code 7'b0001000.
- R5: Two DALU instructions whose positions are equal modulo 4 give code 7'b0010000.
- R6: If the set holds a prefix (class 3'd3), two two-word DALU or AGU instructions must not start at positions of equal parity; otherwise the code is 7'b0100000. Without a prefix this rule is not applied.
- R7: If the set holds both tag 2'b01 (true) and tag 2'b10 (false) instructions, all of one tag must sit at even positions and all of the other at odd positions; otherwise the code is 7'b1000000.
- R8: `viol` is zero or one-hot and shows only the lowest-numbered rule broken. Any violation clears every ALU, AGU and carry valid for that set.
- R9: In a legal set, the DALU at slot p drives `alu_vld[p%4]`, with its slot index in `alu_slot[3*(p%4) +: 3]`. The AGU at slot p drives `agu_vld[p%2]`, with its slot index in `agu_slot[3*(p%2) +: 3]`.
- R10: In a legal set, `cy_vld`/`cy_slot` name the highest-position valid DALU or AGU instruction whose carry flag is set. If there is none, `cy_vld` is low.
- R11: NOP, prefix and extension slots (classes 3'd0, 3'd3, 3'd4) are never dispatched. They count only for contiguity and for the prefix condition.
- R12: A set is taken when `set_valid` and `set_ready` are both high, and `set_ready = !res_valid || res_ready`. The result shows one cycle later with `res_valid` high. While `res_valid && !res_ready`, all outputs hold.
- R13: Synchronous reset clears `res_valid`, every dispatch valid, `cy_vld` and `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_valid | input | 1 | An execution set is offered |
| set_ready | output | 1 | The block can take a set |
| slot_vld | input | 8 | Slot occupied, bit i for slot i |
| slot_cls | input | 24 | Slot class, bits 3i+2:3i |
| slot_two_word | input | 8 | Slot starts a two-word instruction |
| slot_sub | input | 16 | Subgroup tag, bits 2i+1:2i |
| slot_carry | input | 8 | Instruction may update the carry bit |
| res_ready | input | 1 | Downstream accepts the result |
| res_valid | output | 1 | A result is held |
| alu_vld | output | 4 | Dispatch valid per ALU |
| alu_slot | output | 12 | Slot index per ALU, 3 bits each |
| agu_vld | output | 2 | Dispatch valid per AGU |
| agu_slot | output | 6 | Slot index per AGU, 3 bits each |
| cy_vld | output | 1 | A carry owner exists |
| cy_slot | output | 3 | Slot index of the carry owner |
| viol | output | 7 | One-hot violation code |

## Verification
Rule checking and carry-owner selection run on the same set in the same cycle. An illegal set that carries carry-capable instructions must therefore yield no carry owner, and a set that breaks several rules must report only the first of them.

Random sets carry carry flags, two-word flags and subgroup tags, and they often break several rules at once. Directed sets pair a gap with a DALU clash, and a carry flag with a prefix parity error. A bench model works out the expected violation code, routing and carry owner from pairwise position comparisons and compares them after each capture.

// File: rtl/xset_pkg.sv
package xset_pkg;
  localparam int unsigned CLS_W = 3;
  localparam int unsigned SUB_W = 2;
  localparam int unsigned VIOL_W = 7;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP  = 3'd0,
    CLS_DALU = 3'd1,
    CLS_AGU  = 3'd2,
    CLS_PFX  = 3'd3,
    CLS_EXT  = 3'd4
  } slot_cls_e;

  localparam logic [SUB_W-1:0] SUB_TRUE  = 2'b01;
  localparam logic [SUB_W-1:0] SUB_FALSE = 2'b10;

  // violation bit positions, lower index wins
  localparam int unsigned V_GAP      = 0;
  localparam int unsigned V_AGU_CNT  = 1;
  localparam int unsigned V_AGU_PAR  = 2;
  localparam int unsigned V_DALU_CNT = 3;
  localparam int unsigned V_DALU_MOD = 4;
  localparam int unsigned V_TWO_PAR  = 5;
  localparam int unsigned V_SUB_PAR  = 6;

  // keep only the lowest set bit
  function automatic logic [VIOL_W-1:0] first_viol(input logic [VIOL_W-1:0] raw);
    return raw & (~raw + 1'b1);
  endfunction
endpackage

// File: rtl/xset_rules.sv
module xset_rules
  import xset_pkg::*;
#(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned NALU  = 4,
  parameter int unsigned NAGU  = 2
) (
  input  logic [NSLOT-1:0]       slot_vld,
  input  logic [NSLOT*CLS_W-1:0] slot_cls,
  input  logic [NSLOT-1:0]       slot_two_word,
  input  logic [NSLOT*SUB_W-1:0] slot_sub,
  output logic [NSLOT-1:0]       is_dalu,
  output logic [NSLOT-1:0]       is_agu,
  output logic [VIOL_W-1:0]      raw_viol
);
  function automatic logic [NSLOT-1:0] lane_mask(input int unsigned md, input int unsigned r);
    logic [NSLOT-1:0] k;
    for (int unsigned i = 0; i < NSLOT; i++) k[i] = ((i % md) == r);
    return k;
  endfunction

  // true when two members of m share a residue modulo md
  function automatic logic lane_clash(input logic [NSLOT-1:0] m, input int unsigned md);
    logic hit;
    hit = 1'b0;
    for (int unsigned r = 0; r < md; r++) hit |= ($countones(m & lane_mask(md, r)) > 1);
    return hit;
  endfunction

  function automatic logic has_gap(input logic [NSLOT-1:0] m);
    logic g;
    g = 1'b0;
    for (int unsigned i = 1; i < NSLOT; i++) g |= (m[i] && !m[i-1]);
    return g;
  endfunction

  localparam logic [NSLOT-1:0] EVEN_M = lane_mask(2, 0);
  localparam logic [NSLOT-1:0] ODD_M  = lane_mask(2, 1);

  logic [NSLOT-1:0] is_pfx, two_w, in_t, in_f;
  logic             t_even_f_odd, t_odd_f_even, split_set;

  always_comb begin
    for (int unsigned i = 0; i < NSLOT; i++) begin
      is_dalu[i] = slot_vld[i] && (slot_cls[i*CLS_W +: CLS_W] == CLS_DALU);
      is_agu[i]  = slot_vld[i] && (slot_cls[i*CLS_W +: CLS_W] == CLS_AGU);
      is_pfx[i]  = slot_vld[i] && (slot_cls[i*CLS_W +: CLS_W] == CLS_PFX);
      two_w[i]   = (is_dalu[i] || is_agu[i]) && slot_two_word[i];
      in_t[i]    = (is_dalu[i] || is_agu[i]) && (slot_sub[i*SUB_W +: SUB_W] == SUB_TRUE);
      in_f[i]    = (is_dalu[i] || is_agu[i]) && (slot_sub[i*SUB_W +: SUB_W] == SUB_FALSE);
    end
  end

  assign t_even_f_odd = ((in_t & ODD_M) == '0) && ((in_f & EVEN_M) == '0);
  assign t_odd_f_even = ((in_t & EVEN_M) == '0) && ((in_f & ODD_M) == '0);
  assign split_set    = (|in_t) && (|in_f);

  always_comb begin
    raw_viol             = '0;
    raw_viol[V_GAP]      = has_gap(slot_vld);                     // R1
    raw_viol[V_AGU_CNT]  = $countones(is_agu) > NAGU;             // R2
    raw_viol[V_AGU_PAR]  = lane_clash(is_agu, NAGU);              // R3
    raw_viol[V_DALU_CNT] = $countones(is_dalu) > NALU;            // R4
    raw_viol[V_DALU_MOD] = lane_clash(is_dalu, NALU);             // R5
    raw_viol[V_TWO_PAR]  = (|is_pfx) && lane_clash(two_w, 2);     // R6
    raw_viol[V_SUB_PAR]  = split_set && !(t_even_f_odd || t_odd_f_even); // R7
  end
endmodule

// File: rtl/xset_route.sv
module xset_route #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned NALU  = 4,
  parameter int unsigned NAGU  = 2,
  localparam int unsigned IW   = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0]   is_dalu,
  input  logic [NSLOT-1:0]   is_agu,
  input  logic [NSLOT-1:0]   slot_carry,
  output logic [NALU-1:0]    alu_hit,
  output logic [NALU*IW-1:0] alu_pos,
  output logic [NAGU-1:0]    agu_hit,
  output logic [NAGU*IW-1:0] agu_pos,
  output logic               cy_hit,
  output logic [IW-1:0]      cy_pos
);
  // R9: fixed lanes; scanning downward lets the lowest slot win if the set is illegal
  always_comb begin
    alu_hit = '0;
    alu_pos = '0;
    agu_hit = '0;
    agu_pos = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (is_dalu[i]) begin
        alu_hit[i % NALU] = 1'b1;
        alu_pos[(i % NALU)*IW +: IW] = IW'(i);
      end
      if (is_agu[i]) begin
        agu_hit[i % NAGU] = 1'b1;
        agu_pos[(i % NAGU)*IW +: IW] = IW'(i);
      end
    end
  end

  // R10: highest carry-capable instruction owns the carry bit
  always_comb begin
    cy_hit = 1'b0;
    cy_pos = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if ((is_dalu[i] || is_agu[i]) && slot_carry[i]) begin
        cy_hit = 1'b1;
        cy_pos = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xset_stage.sv
module xset_stage
  import xset_pkg::*;
#(
  parameter int unsigned NALU = 4,
  parameter int unsigned NAGU = 2,
  parameter int unsigned IW   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               res_ready,
  input  logic [NALU-1:0]    d_alu_vld,
  input  logic [NALU*IW-1:0] d_alu_slot,
  input  logic [NAGU-1:0]    d_agu_vld,
  input  logic [NAGU*IW-1:0] d_agu_slot,
  input  logic               d_cy_vld,
  input  logic [IW-1:0]      d_cy_slot,
  input  logic [VIOL_W-1:0]  d_viol,
  output logic               res_valid,
  output logic [NALU-1:0]    alu_vld,
  output logic [NALU*IW-1:0] alu_slot,
  output logic [NAGU-1:0]    agu_vld,
  output logic [NAGU*IW-1:0] agu_slot,
  output logic               cy_vld,
  output logic [IW-1:0]      cy_slot,
  output logic [VIOL_W-1:0]  viol
);
  always_ff @(posedge clk) begin
    if (rst) begin                      // R13
      res_valid <= 1'b0;
      alu_vld   <= '0;
      alu_slot  <= '0;
      agu_vld   <= '0;
      agu_slot  <= '0;
      cy_vld    <= 1'b0;
      cy_slot   <= '0;
      viol      <= '0;
    end else if (take) begin            // R12
      res_valid <= 1'b1;
      alu_vld   <= d_alu_vld;
      alu_slot  <= d_alu_slot;
      agu_vld   <= d_agu_vld;
      agu_slot  <= d_agu_slot;
      cy_vld    <= d_cy_vld;
      cy_slot   <= d_cy_slot;
      viol      <= d_viol;
    end else if (res_ready) begin
      res_valid <= 1'b0;
      alu_vld   <= '0;
      agu_vld   <= '0;
      cy_vld    <= 1'b0;
      viol      <= '0;
    end
  end
endmodule

// File: rtl/xset_dispatch.sv
module xset_dispatch
  import xset_pkg::*;
#(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned NALU  = 4,
  parameter int unsigned NAGU  = 2,
  localparam int unsigned IW   = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   set_valid,
  output logic                   set_ready,
  input  logic [NSLOT-1:0]       slot_vld,
  input  logic [NSLOT*CLS_W-1:0] slot_cls,
  input  logic [NSLOT-1:0]       slot_two_word,
  input  logic [NSLOT*SUB_W-1:0] slot_sub,
  input  logic [NSLOT-1:0]       slot_carry,
  input  logic                   res_ready,
  output logic                   res_valid,
  output logic [NALU-1:0]        alu_vld,
  output logic [NALU*IW-1:0]     alu_slot,
  output logic [NAGU-1:0]        agu_vld,
  output logic [NAGU*IW-1:0]     agu_slot,
  output logic                   cy_vld,
  output logic [IW-1:0]          cy_slot,
  output logic [VIOL_W-1:0]      viol
);
  logic [NSLOT-1:0]   is_dalu, is_agu;
  logic [VIOL_W-1:0]  raw_viol, sel_viol;
  logic               legal, take;
  logic [NALU-1:0]    alu_hit;
  logic [NALU*IW-1:0] alu_pos;
  logic [NAGU-1:0]    agu_hit;
  logic [NAGU*IW-1:0] agu_pos;
  logic               cy_hit;
  logic [IW-1:0]      cy_pos;

  xset_rules #(.NSLOT(NSLOT), .NALU(NALU), .NAGU(NAGU)) u_rules (
    .slot_vld(slot_vld), .slot_cls(slot_cls), .slot_two_word(slot_two_word),
    .slot_sub(slot_sub), .is_dalu(is_dalu), .is_agu(is_agu), .raw_viol(raw_viol)
  );

  xset_route #(.NSLOT(NSLOT), .NALU(NALU), .NAGU(NAGU)) u_route (
    .is_dalu(is_dalu), .is_agu(is_agu), .slot_carry(slot_carry),
    .alu_hit(alu_hit), .alu_pos(alu_pos), .agu_hit(agu_hit), .agu_pos(agu_pos),
    .cy_hit(cy_hit), .cy_pos(cy_pos)
  );

  assign sel_viol  = first_viol(raw_viol);          // R8
  assign legal     = (raw_viol == '0);
  assign set_ready = !res_valid || res_ready;       // R12
  assign take      = set_valid && set_ready;

  xset_stage #(.NALU(NALU), .NAGU(NAGU), .IW(IW)) u_stage (
    .clk(clk), .rst(rst), .take(take), .res_ready(res_ready),
    .d_alu_vld(legal ? alu_hit : '0), .d_alu_slot(alu_pos),
    .d_agu_vld(legal ? agu_hit : '0), .d_agu_slot(agu_pos),
    .d_cy_vld(legal && cy_hit), .d_cy_slot(cy_pos), .d_viol(sel_viol),
    .res_valid(res_valid), .alu_vld(alu_vld), .alu_slot(alu_slot),
    .agu_vld(agu_vld), .agu_slot(agu_slot), .cy_vld(cy_vld), .cy_slot(cy_slot),
    .viol(viol)
  );
endmodule

// File: rtl/xset_dispatch_sva.sv
module xset_dispatch_sva
  import xset_pkg::*;
#(
  parameter int unsigned NALU = 4,
  parameter int unsigned NAGU = 2,
  parameter int unsigned IW   = 3,
  localparam int unsigned LA  = $clog2(NALU),
  localparam int unsigned LG  = $clog2(NAGU)
) (
  input logic               clk,
  input logic               rst,
  input logic               take,
  input logic               res_valid,
  input logic               res_ready,
  input logic [NALU-1:0]    alu_vld,
  input logic [NALU*IW-1:0] alu_slot,
  input logic [NAGU-1:0]    agu_vld,
  input logic [NAGU*IW-1:0] agu_slot,
  input logic               cy_vld,
  input logic [VIOL_W-1:0]  viol
);
  // R8
  viol_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(viol));

  // R8
  viol_mutes_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (viol != '0) |-> (alu_vld == '0 && agu_vld == '0 && !cy_vld));

  // R12
  capture_chk: assert property (@(posedge clk) disable iff (rst) take |=> res_valid);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready && !take) |=> (res_valid && $stable(alu_vld) && $stable(alu_slot)
      && $stable(agu_vld) && $stable(agu_slot) && $stable(cy_vld) && $stable(viol)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (alu_vld == '0 && agu_vld == '0 && !cy_vld && viol == '0));

  // R13
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && alu_vld == '0 && agu_vld == '0 && !cy_vld && viol == '0));

  for (genvar u = 0; u < NALU; u++) begin : g_alu
    // R9
    alu_lane_chk: assert property (@(posedge clk) disable iff (rst)
      alu_vld[u] |-> (alu_slot[u*IW +: LA] == LA'(u)));
  end

  for (genvar g = 0; g < NAGU; g++) begin : g_agu
    // R9
    agu_lane_chk: assert property (@(posedge clk) disable iff (rst)
      agu_vld[g] |-> (agu_slot[g*IW +: LG] == LG'(g)));
  end
endmodule

bind xset_dispatch xset_dispatch_sva #(.NALU(NALU), .NAGU(NAGU), .IW(IW)) u_sva (
  .clk(clk), .rst(rst), .take(take), .res_valid(res_valid), .res_ready(res_ready),
  .alu_vld(alu_vld), .alu_slot(alu_slot), .agu_vld(agu_vld), .agu_slot(agu_slot),
  .cy_vld(cy_vld), .viol(viol)
);

// File: tb/test_xset_dispatch.sv
`timescale 1ns/1ps
module test_xset_dispatch;
  import xset_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_valid = 1'b0, res_ready = 1'b1;
  logic [7:0]  s_vld = '0, s_w2 = '0, s_cy = '0;
  logic [23:0] s_cls = '0;
  logic [15:0] s_sub = '0;
  logic        set_ready, res_valid, cy_vld;
  logic [3:0]  alu_vld;
  logic [11:0] alu_slot;
  logic [1:0]  agu_vld;
  logic [5:0]  agu_slot;
  logic [2:0]  cy_slot;
  logic [6:0]  viol;

  int checks = 0, fails = 0;
  logic [6:0] e_viol;
  logic [3:0] e_alu_vld;
  logic [1:0] e_agu_vld;
  int         e_alu_slot [4];
  int         e_agu_slot [2];
  logic       e_cy_vld;
  int         e_cy_slot;

  always #2 clk = ~clk;

  xset_dispatch i_xset_dispatch (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_ready(set_ready),
    .slot_vld(s_vld), .slot_cls(s_cls), .slot_two_word(s_w2), .slot_sub(s_sub),
    .slot_carry(s_cy), .res_ready(res_ready), .res_valid(res_valid),
    .alu_vld(alu_vld), .alu_slot(alu_slot), .agu_vld(agu_vld), .agu_slot(agu_slot),
    .cy_vld(cy_vld), .cy_slot(cy_slot), .viol(viol)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cl(int i);
    return int'(s_cls[i*3 +: 3]);
  endfunction
  function automatic bit ins(int i);
    return s_vld[i] && (cl(i) == 1 || cl(i) == 2);
  endfunction

  // independent model: pairwise comparisons of positions
  task automatic model();
    logic [6:0] raw;
    int nd, na;
    bit pfx, any_t, any_f;
    raw = '0; nd = 0; na = 0; pfx = 0; any_t = 0; any_f = 0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0 && s_vld[i] && !s_vld[i-1]) raw[0] = 1;
      if (s_vld[i] && cl(i) == 1) nd++;
      if (s_vld[i] && cl(i) == 2) na++;
      if (s_vld[i] && cl(i) == 3) pfx = 1;
      if (ins(i) && s_sub[2*i +: 2] == 2'b01) any_t = 1;
      if (ins(i) && s_sub[2*i +: 2] == 2'b10) any_f = 1;
    end
    if (na > 2) raw[1] = 1;
    if (nd > 4) raw[3] = 1;
    for (int i = 0; i < 8; i++)
      for (int j = i + 1; j < 8; j++) begin
        if (s_vld[i] && s_vld[j] && cl(i) == 2 && cl(j) == 2 && (i % 2) == (j % 2)) raw[2] = 1;
        if (s_vld[i] && s_vld[j] && cl(i) == 1 && cl(j) == 1 && (i % 4) == (j % 4)) raw[4] = 1;
        if (pfx && ins(i) && ins(j) && s_w2[i] && s_w2[j] && (i % 2) == (j % 2)) raw[5] = 1;
        if (any_t && any_f && ins(i) && ins(j)) begin
          if (s_sub[2*i +: 2] == s_sub[2*j +: 2] && (s_sub[2*i +: 2] == 2'b01 || s_sub[2*i +: 2] == 2'b10)
              && (i % 2) != (j % 2)) raw[6] = 1;
          if (((s_sub[2*i +: 2] == 2'b01 && s_sub[2*j +: 2] == 2'b10) ||
               (s_sub[2*i +: 2] == 2'b10 && s_sub[2*j +: 2] == 2'b01)) && (i % 2) == (j % 2)) raw[6] = 1;
        end
      end
    e_viol = '0;
    for (int k = 6; k >= 0; k--) if (raw[k]) e_viol = 7'(1 << k);
    e_alu_vld = '0; e_agu_vld = '0; e_cy_vld = 0; e_cy_slot = 0;
    for (int u = 0; u < 4; u++) e_alu_slot[u] = 0;
    for (int u = 0; u < 2; u++) e_agu_slot[u] = 0;
    if (e_viol == 0)
      for (int i = 0; i < 8; i++) begin
        if (s_vld[i] && cl(i) == 1) begin e_alu_vld[i % 4] = 1; e_alu_slot[i % 4] = i; end
        if (s_vld[i] && cl(i) == 2) begin e_agu_vld[i % 2] = 1; e_agu_slot[i % 2] = i; end
        if (ins(i) && s_cy[i]) begin e_cy_vld = 1; e_cy_slot = i; end
      end
  endtask

  task automatic compare_all();
    chk("R12", "res_valid", int'(res_valid), 1);
    chk("R8", "viol", int'(viol), int'(e_viol));
    chk("R9", "alu_vld", int'(alu_vld), int'(e_alu_vld));
    chk("R9", "agu_vld", int'(agu_vld), int'(e_agu_vld));
    for (int u = 0; u < 4; u++)
      if (e_alu_vld[u]) chk("R9", "alu_slot", int'(alu_slot[u*3 +: 3]), e_alu_slot[u]);
    for (int u = 0; u < 2; u++)
      if (e_agu_vld[u]) chk("R9", "agu_slot", int'(agu_slot[u*3 +: 3]), e_agu_slot[u]);
    chk("R10", "cy_vld", int'(cy_vld), int'(e_cy_vld));
    if (e_cy_vld) chk("R10", "cy_slot", int'(cy_slot), e_cy_slot);
  endtask

  task automatic clr_set();
    s_vld = '0; s_cls = '0; s_w2 = '0; s_sub = '0; s_cy = '0;
  endtask

  task automatic put(int i, logic [2:0] c, bit w2 = 0, logic [1:0] sg = 2'b00, bit cy = 0);
    s_vld[i] = 1'b1; s_cls[i*3 +: 3] = c; s_w2[i] = w2; s_sub[2*i +: 2] = sg; s_cy[i] = cy;
  endtask

  // drive at a falling edge, capture at the next rise, check at the next fall
  task automatic run_set();
    model();
    set_valid = 1'b1; res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    set_valid = 1'b0;
    compare_all();
  endtask

  initial begin : watchdog
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int n, r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R13", "res_valid at reset", int'(res_valid), 0);
    chk("R13", "alu_vld at reset", int'(alu_vld), 0);
    chk("R13", "viol at reset", int'(viol), 0);
    chk("R12", "set_ready idle", int'(set_ready), 1);
    rst = 1'b0;
    @(negedge clk);

    // R1: hole at slot 1
    clr_set(); put(0, CLS_DALU); put(2, CLS_DALU); run_set();
    chk("R1", "gap code", int'(viol), 1);
    // R2: three AGUs
    clr_set(); put(0, CLS_AGU); put(1, CLS_AGU); put(2, CLS_AGU); run_set();
    chk("R2", "agu count code", int'(viol), 2);
    // R3: two even AGUs, then a lone AGU at slot 3
    clr_set(); put(0, CLS_AGU); put(1, CLS_DALU); put(2, CLS_AGU); run_set();
    chk("R3", "agu parity code", int'(viol), 4);
    clr_set(); put(0, CLS_DALU); put(1, CLS_DALU); put(2, CLS_DALU); put(3, CLS_AGU); run_set();
    chk("R3", "lone agu legal", int'(viol), 0);
    chk("R9", "lone agu lane", int'(agu_vld), 2);
    // R4: five DALUs
    clr_set(); for (int i = 0; i < 5; i++) put(i, CLS_DALU); run_set();
    chk("R4", "dalu count code", int'(viol), 8);
    // R5: DALUs at 1 and 5
    clr_set(); put(0, CLS_AGU); put(1, CLS_DALU); for (int i = 2; i < 5; i++) put(i, CLS_NOP);
    put(5, CLS_DALU); run_set();
    chk("R5", "dalu modulo code", int'(viol), 16);
    // R6: prefix with two odd two-word starts, carry flag present
    clr_set(); put(0, CLS_PFX); put(1, CLS_DALU, 1, 0, 1); put(2, CLS_EXT); put(3, CLS_DALU, 1); put(4, CLS_EXT);
    run_set();
    chk("R6", "two-word parity code", int'(viol), 32);
    chk("R8", "no carry owner when illegal", int'(cy_vld), 0);
    clr_set(); put(0, CLS_NOP); put(1, CLS_DALU, 1); put(2, CLS_EXT); put(3, CLS_DALU, 1); put(4, CLS_EXT);
    run_set();
    chk("R6", "no prefix no rule", int'(viol), 0);
    // R11: legal prefix set, prefix/ext/nop never dispatched
    clr_set(); put(0, CLS_PFX); put(1, CLS_DALU, 1); put(2, CLS_EXT); put(3, CLS_DALU); put(4, CLS_DALU, 1);
    put(5, CLS_EXT); put(6, CLS_NOP); run_set();
    chk("R11", "only dalus dispatched", int'(alu_vld), 4'b1011);
    chk("R11", "no agu dispatched", int'(agu_vld), 0);
    // R7: legal split and broken split
    clr_set(); put(0, CLS_DALU, 0, 2'b01); put(1, CLS_DALU, 0, 2'b10); put(2, CLS_DALU, 0, 2'b01);
    put(3, CLS_AGU, 0, 2'b10); run_set();
    chk("R7", "interleaved subgroups legal", int'(viol), 0);
    clr_set(); put(0, CLS_DALU, 0, 2'b01); put(1, CLS_AGU); put(2, CLS_DALU, 0, 2'b10); run_set();
    chk("R7", "subgroup parity code", int'(viol), 64);
    // R8: gap plus modulo clash reports only the gap
    clr_set(); put(0, CLS_DALU); put(2, CLS_DALU); put(3, CLS_DALU); put(4, CLS_DALU); run_set();
    chk("R8", "priority to gap", int'(viol), 1);
    chk("R8", "dispatch muted", int'(alu_vld), 0);
    // R10: highest carry owner
    clr_set(); put(0, CLS_DALU); put(1, CLS_DALU, 0, 0, 1); put(2, CLS_AGU); put(3, CLS_DALU, 0, 0, 1);
    put(4, CLS_NOP, 0, 0, 1); run_set();
    chk("R10", "highest carry owner", int'(cy_slot), 3);

    // R12: hold under stall, new set refused
    set_valid = 1'b0; res_ready = 1'b1; @(posedge clk); @(negedge clk);
    clr_set(); put(0, CLS_DALU, 0, 0, 1); put(1, CLS_AGU); model();
    set_valid = 1'b1; res_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R12", "set_ready during stall", int'(set_ready), 0);
    clr_set(); put(0, CLS_AGU); put(1, CLS_AGU); put(2, CLS_AGU);
    @(posedge clk); @(negedge clk);
    compare_all();
    model(); res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    set_valid = 1'b0;
    compare_all();
    chk("R12", "new set after stall", int'(viol), 2);

    // random sets
    for (int it = 0; it < 600; it++) begin
      clr_set();
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) begin
        r = int'($urandom % 10);
        put(i, r < 4 ? CLS_DALU : r < 6 ? CLS_AGU : r < 8 ? CLS_NOP : r < 9 ? CLS_PFX : CLS_EXT,
            ($urandom % 4) == 0, ($urandom % 3) == 0 ? 2'($urandom % 4) : 2'b00, ($urandom % 3) == 0);
      end
      if (n > 2 && ($urandom % 8) == 0) s_vld[1 + int'($urandom % (n - 2))] = 1'b0;
      run_set();
    end

    // R13: reset in the middle of a held result
    clr_set(); put(0, CLS_DALU); run_set();
    rst = 1'b1; @(posedge clk); @(negedge clk);
    chk("R13", "res_valid after reset", int'(res_valid), 0);
    chk("R13", "alu_vld after reset", int'(alu_vld), 0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule